// File: doc/BRIEF.md
# Two-Wire Memory Target Front End

This block is the bus-facing half of a serial memory that sits on a two-wire (I2C) bus as a target. Both bus lines are sampled by a fast system clock, at least eight times the SCL rate. The lines pass through a short synchronizer chain, and the block detects edges and bus conditions on the synchronized copies. The block decodes Start and Stop conditions and shifts in bytes, one bit for each SCL pulse, most significant bit first. It acknowledges a byte by pulling SDA low across the ninth clock. During a read it shifts bytes out and reads the master's acknowledge.

The first byte after any Start holds a 7-bit device address followed by a direction bit. The block answers only when the address matches its parameter. While the memory core reports that an internal programming cycle is busy, the block acknowledges nothing, and it then stays passive until the next Start or Stop. Written data bytes leave the block as a one-cycle strobe carrying the byte. For reads, the block takes the byte presented at `tx_byte_i` and raises a one-cycle request so that the memory side can present the next one. SDA is handled as an open-drain line: the only output is an active-low pull-down enable, and the block never drives the line high.

Top module: `eeprom_i2c_target`

## Requirements
- R1: During and after reset, with the bus idle, `sda_oe_n_o` is 1 (released) and `start_o`, `stop_o`, `rx_valid_o` and `rd_req_o` are 0.
- R2: A falling SDA while SCL is high gives one `start_o` pulse, and a rising SDA while SCL is high gives one `stop_o` pulse. SDA changes while SCL is low give neither pulse.
- R3: The first byte after a Start is taken MSB first: bits 7..1 are the device address and bit 0 is the direction (1 = read). When the address equals `DEV_ADDR` and `busy_i` is low, SDA is held low for the whole high phase of the ninth SCL pulse.
- R4: After an address that does not match, the block gives no acknowledge, keeps SDA released and strobes no byte until the next Start.
- R5: In a write, each data byte after the address is acknowledged and produces exactly one `rx_valid_o` pulse with the byte on `rx_byte_o`. The address byte itself is never strobed.
- R6: If `busy_i` is high when a byte completes, that byte (address or data) gets no acknowledge and no strobe. The block then acknowledges nothing more until the next Start, even after `busy_i` falls.
- R7: In a read, the block sends the byte sampled from `tx_byte_i` MSB first, with a 1 bit left released. It pulses `rd_req_o` once each time it takes a byte: at the end of the address acknowledge and at the end of each master acknowledge.
- R8: A master acknowledge (SDA low on the ninth clock of a read byte) makes the block send the next byte.
- R9: A master not-acknowledge makes the block release SDA and stop sending. Further clocks read all ones and take no new byte.
- R10: A Start seen in the middle of a byte, or after a complete byte, discards the partial byte and restarts address reception.
- R11: After a Stop, clock pulses with no Start are ignored: no acknowledge and no strobe.
- R12: The pull-down enable only changes while SCL is low, so SDA stays steady across every SCL high phase that the block drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad (the wired-AND result) |
| busy_i | input | 1 | High while the memory runs an internal programming cycle |
| tx_byte_i | input | 8 | Byte to send on the next read byte |
| sda_oe_n_o | output | 1 | Active-low SDA pull-down enable (0 = pull low, 1 = release) |
| start_o | output | 1 | One-cycle pulse on each Start (including repeated Start) |
| stop_o | output | 1 | One-cycle pulse on each Stop |
| rx_valid_o | output | 1 | One-cycle strobe for an acknowledged written data byte |
| rx_byte_o | output | 8 | Received byte, valid while `rx_valid_o` is high |
| rd_req_o | output | 1 | One-cycle pulse when `tx_byte_i` has been taken |

## Verification
The bench builds the block with `DEV_ADDR = 7'h5A` instead of the default. This shows that the match comes from the parameter and not from a fixed value, and lets nearby addresses serve as mismatches. It also sets `SYNC_STAGES = 3`, which lengthens the path from pad to edge detection while staying inside the eight-cycle quarter period of the emulated master. This confirms that decisions taken at SCL edges still land within the low phase. The byte patterns and the read data source (a function of the request count) are chosen so that both 0 and 1 bits appear in every bit position.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_IGN
  } tgt_state_e;

  // device address sits in the upper bits, direction in bit 0
  function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] dev);
    return b[BYTE_W-1 -: ADDR_W] == dev;
  endfunction

  // acknowledge decision for a completed byte
  function automatic logic give_ack(input logic is_addr,
                                    input logic match,
                                    input logic busy);
    return !busy && (match || !is_addr);
  endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int NST = (STAGES < 2) ? 2 : STAGES;

  logic [W-1:0] stg_q [NST];

  // idle bus reads high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < NST; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[NST-1];

endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

  // R2
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !start_p);

  // R2
  stop_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !stop_p);

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              pull_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rd_req_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_sh_q;
  logic [BYTE_W-1:0] tx_sh_q;
  logic              is_addr_q;
  logic              rd_dir_q;
  logic              mack_q;
  logic              pull_q;
  logic              rx_valid_q;
  logic              rd_req_q;

  // named events used by the logic and the checks
  logic byte_done;
  logic ack_now;

  assign byte_done = (st_q == ST_RX) && scl_fall && (cnt_q == CNT_FULL);
  assign ack_now   = give_ack(is_addr_q, addr_match(rx_sh_q, DEV_ADDR), busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      is_addr_q  <= 1'b0;
      rd_dir_q   <= 1'b0;
      mack_q     <= 1'b0;
      pull_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
      if (start_p) begin
        st_q      <= ST_RX;
        cnt_q     <= '0;
        is_addr_q <= 1'b1;
        pull_q    <= 1'b0;
      end else if (stop_p) begin
        st_q   <= ST_IDLE;
        cnt_q  <= '0;
        pull_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise && cnt_q != CNT_FULL) begin
              rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_s};
              cnt_q   <= cnt_q + 1'b1;
            end else if (byte_done) begin
              if (ack_now) begin
                pull_q <= 1'b1;
                st_q   <= ST_RXACK;
                if (is_addr_q) rd_dir_q <= rx_sh_q[0];
                else           rx_valid_q <= 1'b1;
              end else begin
                st_q <= ST_IGN;
              end
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              cnt_q     <= '0;
              is_addr_q <= 1'b0;
              if (is_addr_q && rd_dir_q) begin
                tx_sh_q  <= tx_byte_i;
                pull_q   <= ~tx_byte_i[BYTE_W-1];
                rd_req_q <= 1'b1;
                st_q     <= ST_TX;
              end else begin
                pull_q <= 1'b0;
                st_q   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == CNT_LAST) begin
                pull_q <= 1'b0;
                cnt_q  <= '0;
                st_q   <= ST_TXACK;
              end else begin
                tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                pull_q  <= ~tx_sh_q[BYTE_W-2];
                cnt_q   <= cnt_q + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_sh_q  <= tx_byte_i;
                pull_q   <= ~tx_byte_i[BYTE_W-1];
                rd_req_q <= 1'b1;
                st_q     <= ST_TX;
              end else begin
                st_q <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pull_o     = pull_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = rx_sh_q;
  assign rd_req_o   = rd_req_q;

  // R12
  pull_on_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl_s);

  // R6
  no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RXACK && $past(st_q) != ST_RXACK) |-> !$past(busy_i));

  // R4
  ign_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGN) |-> !pull_q);

  // R9
  mack_phase_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TXACK) |-> !pull_q);

  // R5
  strobe_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> (pull_q && st_q == ST_RXACK));

  // R10
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st_q == ST_RX && cnt_q == '0 && is_addr_q));

  // R7
  req_enters_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_q |-> (st_q == ST_TX && cnt_q == '0));

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       busy_i,
  input  logic [7:0] tx_byte_i,
  output logic       sda_oe_n_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       rd_req_o
);

  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_p, stop_p;
  logic       pull;

  i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2ct_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  i2ct_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_p    (start_p),
    .stop_p     (stop_p),
    .busy_i     (busy_i),
    .tx_byte_i  (tx_byte_i),
    .pull_o     (pull),
    .rx_valid_o (rx_valid_o),
    .rx_byte_o  (rx_byte_o),
    .rd_req_o   (rd_req_o)
  );

  // open drain: only a pull-down enable leaves the block
  assign sda_oe_n_o = ~pull;
  assign start_o    = start_p;
  assign stop_o     = stop_p;

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sda_oe_n_o);

  // R2
  cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !stop_o);

endmodule

// File: tb/eeprom_i2c_target_tb_top.sv
module eeprom_i2c_target_tb_top;

  localparam logic [6:0] ADDR = 7'h5A;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic busy = 1'b0;
  logic [7:0] tx_byte;
  logic sda_oe_n, start_w, stop_w, rx_valid, rd_req;
  logic [7:0] rx_byte;
  logic sda_bus;

  int n_tests = 0;
  int n_fail = 0;
  int start_cnt = 0, stop_cnt = 0, rx_cnt = 0, rd_cnt = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input int k);
    return 8'h96 ^ 8'(k * 37);
  endfunction

  assign tx_byte = pat(rd_cnt);
  assign sda_bus = m_sda & sda_oe_n;

  eeprom_i2c_target #(.DEV_ADDR(ADDR), .SYNC_STAGES(3)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .busy_i     (busy),
    .tx_byte_i  (tx_byte),
    .sda_oe_n_o (sda_oe_n),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .rx_valid_o (rx_valid),
    .rx_byte_o  (rx_byte),
    .rd_req_o   (rd_req)
  );

  always @(negedge clk) begin
    if (start_w) start_cnt++;
    if (stop_w) stop_cnt++;
    if (rd_req) rd_cnt++;
    if (rx_valid) begin rx_cnt++; last_rx = rx_byte; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); s1 = sda_bus; wq(); s2 = sda_bus;
    m_scl = 1'b0; wq();
    ack = !s1 && !s2;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b, output bit steady);
    logic s1, s2;
    steady = 1;
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); m_scl = 1'b1; wq(); s1 = sda_bus; wq(); s2 = sda_bus;
      b = {b[6:0], s1};
      if (s1 !== s2) steady = 0;
      m_scl = 1'b0;
    end
    wq(); m_sda = give_ack ? 1'b0 : 1'b1; wq(); m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq(); m_sda = 1'b1;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(sda_oe_n === 1'b1, "R1 oe in reset", sda_oe_n, 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sda_oe_n === 1'b1 && !start_w && !stop_w && !rx_valid && !rd_req,
        "R1 idle outputs", {sda_oe_n, start_w, stop_w, rx_valid, rd_req}, 5'b10000);
  endtask

  task automatic t_conditions();
    int s0 = start_cnt, p0 = stop_cnt;
    bus_start();
    chk(start_cnt == s0 + 1, "R2 start pulse", start_cnt - s0, 1);
    m_sda = 1'b1; wq(); m_sda = 1'b0; wq(); m_sda = 1'b1; wq();
    chk(start_cnt == s0 + 1 && stop_cnt == p0, "R2 low-phase toggles",
        (start_cnt - s0) * 16 + (stop_cnt - p0), 16);
    bus_stop();
    chk(stop_cnt == p0 + 1, "R2 stop pulse", stop_cnt - p0, 1);
  endtask

  task automatic t_write();
    bit a;
    int r0 = rx_cnt;
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    chk(a, "R3 address ack", a, 1);
    chk(rx_cnt == r0, "R5 address not strobed", rx_cnt - r0, 0);
    put_byte(8'h3C, a);
    chk(a && rx_cnt == r0 + 1 && last_rx == 8'h3C, "R5 first data byte", last_rx, 8'h3C);
    put_byte(8'hC5, a);
    chk(a && rx_cnt == r0 + 2 && last_rx == 8'hC5, "R5 second data byte", last_rx, 8'hC5);
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a;
    int r0 = rx_cnt;
    bus_start();
    put_byte({ADDR ^ 7'h01, 1'b0}, a);
    chk(!a, "R4 mismatch nack", a, 0);
    put_byte(8'h00, a);
    chk(!a && rx_cnt == r0, "R4 no data after mismatch", rx_cnt - r0, 0);
    bus_stop();
    bus_start();
    put_byte({ADDR ^ 7'h40, 1'b1}, a);
    chk(!a && rd_req == 1'b0, "R4 read mismatch nack", a, 0);
    bus_stop();
  endtask

  task automatic t_busy();
    bit a;
    int r0 = rx_cnt;
    busy = 1'b1;
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    chk(!a, "R6 busy address nack", a, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    chk(a, "R6 address ack when idle", a, 1);
    busy = 1'b1;
    put_byte(8'h55, a);
    chk(!a && rx_cnt == r0, "R6 busy data nack", rx_cnt - r0, 0);
    busy = 1'b0;
    put_byte(8'hAA, a);
    chk(!a && rx_cnt == r0, "R6 stays passive", rx_cnt - r0, 0);
    bus_stop();
  endtask

  task automatic t_read();
    bit a, st;
    logic [7:0] b;
    int k0;
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    chk(a, "R10 write address before restart", a, 1);
    bus_start();
    k0 = rd_cnt;
    put_byte({ADDR, 1'b1}, a);
    chk(a, "R10 address after repeated start", a, 1);
    get_byte(1'b1, b, st);
    chk(b == pat(k0), "R7 first read byte", b, pat(k0));
    chk(st, "R12 steady while SCL high", st, 1);
    get_byte(1'b1, b, st);
    chk(b == pat(k0 + 1), "R8 byte after master ack", b, pat(k0 + 1));
    get_byte(1'b0, b, st);
    chk(b == pat(k0 + 2) && st, "R7 third read byte", b, pat(k0 + 2));
    chk(rd_cnt == k0 + 3, "R7 request count", rd_cnt - k0, 3);
    get_byte(1'b0, b, st);
    chk(b == 8'hFF, "R9 released after nack", b, 8'hFF);
    chk(rd_cnt == k0 + 3, "R9 no new byte taken", rd_cnt - k0, 3);
    bus_stop();
  endtask

  task automatic t_restart_mid();
    bit a;
    int s0 = start_cnt;
    bus_start();
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    chk(a && start_cnt == s0 + 2, "R10 mid-byte restart", a, 1);
    bus_stop();
  endtask

  task automatic t_no_start();
    bit a;
    int r0 = rx_cnt;
    wq();
    put_byte({ADDR, 1'b0}, a);
    chk(!a, "R11 address without start", a, 0);
    put_byte(8'h81, a);
    chk(!a && rx_cnt == r0, "R11 data without start", rx_cnt - r0, 0);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
  endtask

  initial begin
    t_reset();
    t_conditions();
    t_write();
    t_mismatch();
    t_busy();
    t_read();
    t_restart_mid();
    t_no_start();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule